// File: doc/BRIEF.md
# CPU Clock Source and Divider Control Bank

This block is the register-facing half of a CPU clock domain controller. Software reaches it through a simple word-wide register bus. Through it, software picks the parent of the core clock, picks the parent of a performance-monitor clock, and programs four 3-bit divide ratios: core, debug trace, copy and performance monitor. The block holds these settings and drives them straight to the clock generation logic. The glitch-free switching circuits themselves are not part of this block.

The status registers lag the control writes, as real clock hardware does. After the core parent bit changes, the mux status field shows a "moving" code for a programmable number of cycles. It then reports the encoded parent that is now active. After a divider register is written, each ratio field whose value actually changed raises its own busy bit for a programmable number of cycles. Software polls these status registers before it goes on with the next step of a frequency change. Settling is modelled with counters.

Top module: `clkctl_bank`

## Requirements
- R1: After reset, the core parent is the main PLL, the performance-monitor parent is 0, every ratio is 0, the mux status register (offset 0x200) reads 0x00010000, and both divider status registers read 0.
- R2: The source register at offset 0x000 stores bit 16 (core parent: 0 = main PLL, 1 = alternate) and bit 20 (performance-monitor parent). It reads them back with every other bit zero and drives them on `core_src_alt` and `perfmon_src`.
- R3: The mux status field occupies bits 18:16 of offset 0x200. A write that changes bit 16 makes this field read 4 from the next cycle on.
- R4: The field keeps reading 4 for `mux_settle` cycles, where a value of 0 counts as 1. It then reads 1 if the main PLL is selected or 2 if the alternate source is selected.
- R5: A source write that leaves bit 16 unchanged starts no switch, and the mux status keeps its value.
- R6: Divider 0 at offset 0x300 holds the core ratio in bits 2:0 and the trace ratio in bits 18:16. Divider 1 at offset 0x304 holds the copy ratio in bits 2:0 and the performance-monitor ratio in bits 6:4. Written ratios read back and appear on the ratio outputs one cycle after the write.
- R7: When a write changes a ratio field, the busy bit at that field's lowest bit position is set in the matching status register (offset 0x400 for divider 0, 0x404 for divider 1). The bit stays set for `div_settle` cycles, where a value of 0 counts as 1, and then clears.
- R8: A ratio field written with its current value raises no busy bit.
- R9: Writes to the status registers or to unmapped offsets change no state. Unmapped offsets read 0.
- R10: A changing write that arrives while a switch or a field is still settling restarts that settle count from the full value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| mux_settle | input | CNT_W | Settle cycles for a core parent switch |
| div_settle | input | CNT_W | Settle cycles for a ratio change |
| core_src_alt | output | 1 | Core parent select, 1 = alternate source |
| perfmon_src | output | 1 | Performance-monitor parent select |
| core_ratio | output | 3 | Core divide ratio (divides by value + 1) |
| trace_ratio | output | 3 | Debug trace divide ratio |
| copy_ratio | output | 3 | Copy divide ratio |
| perfmon_ratio | output | 3 | Performance-monitor divide ratio |

## Verification
The parent switch is tested in both directions, with a multi-cycle settle and with a zero settle. This separates the "moving" window from the final encoding and checks the minimum-of-one rule. Divider writes are tested in three forms: both fields changing, one field changing, and an identical rewrite. This shows that busy bits are tracked per field and not per register. A second changing write in the middle of a settle shows that the count restarts and does not simply run out. Writes to status and unmapped offsets, followed by read-back of every register, show that these writes have no effect.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int RATIO_W = 3;
    localparam int NUM_FIELDS = 4;

    localparam logic [11:0] OFS_SRC   = 12'h000;
    localparam logic [11:0] OFS_MSTAT = 12'h200;
    localparam logic [11:0] OFS_DIV0  = 12'h300;
    localparam logic [11:0] OFS_DIV1  = 12'h304;
    localparam logic [11:0] OFS_DST0  = 12'h400;
    localparam logic [11:0] OFS_DST1  = 12'h404;

    localparam int CORE_SEL_BIT = 16;
    localparam int PERF_SEL_BIT = 20;
    localparam int MSTAT_LSB    = 16;

    typedef enum logic [2:0] {
        MUXC_MAIN   = 3'd1,
        MUXC_ALT    = 3'd2,
        MUXC_MOVING = 3'd4
    } mux_code_e;

    // field index: 0 core, 1 trace, 2 copy, 3 perfmon
    function automatic int field_lsb(input int idx);
        case (idx)
            0: return 0;
            1: return 16;
            2: return 0;
            default: return 4;
        endcase
    endfunction

    // which divider register a field lives in (0 or 1)
    function automatic int field_reg(input int idx);
        return (idx >= 2) ? 1 : 0;
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load;
        end else if (busy) begin
            if (cnt <= CNT_W'(1)) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/mux_tracker.sv
module mux_tracker
    import clkctl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             sel_new,
    input  logic [CNT_W-1:0] settle,
    output logic             sel,
    output mux_code_e        code
);
    logic start;
    logic busy;

    assign start = wr_en && (sel_new != sel);

    always_ff @(posedge clk) begin
        if (rst)        sel <= 1'b0;
        else if (wr_en) sel <= sel_new;
    end

    settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .start(start), .load(settle), .busy(busy)
    );

    always_comb begin
        if (busy)     code = MUXC_MOVING;
        else if (sel) code = MUXC_ALT;
        else          code = MUXC_MAIN;
    end

    // R3: a changing select write shows the moving code next cycle
    p_switch_moving_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_new != sel) |=> (code == MUXC_MOVING));

    // R5: an unchanged select write while settled keeps the code
    p_same_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_new == sel && code != MUXC_MOVING) |=> $stable(code));

    // R4: the code is always one of the three legal values
    p_code_legal_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(code) == 1);

    // R4: leaving the moving state lands on the selected parent
    p_settle_target_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(code) == MUXC_MOVING && code != MUXC_MOVING) |->
        (code == (sel ? MUXC_ALT : MUXC_MAIN)));

endmodule

// File: rtl/div_field.sv
module div_field
    import clkctl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] val_new,
    input  logic [CNT_W-1:0]   settle,
    output logic [RATIO_W-1:0] ratio,
    output logic               busy
);
    logic start;

    assign start = wr_en && (val_new != ratio);

    always_ff @(posedge clk) begin
        if (rst)        ratio <= '0;
        else if (wr_en) ratio <= val_new;
    end

    settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .start(start), .load(settle), .busy(busy)
    );

    // R7: a changed ratio raises busy on the next cycle
    p_change_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && val_new != ratio) |=> busy);

    // R8: an identical write while idle leaves busy clear
    p_same_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && val_new == ratio && !busy) |=> !busy);

    // R6: the ratio only moves on a write
    p_ratio_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ratio));

endmodule

// File: rtl/clkctl_bank.sv
module clkctl_bank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]   mux_settle,
    input  logic [CNT_W-1:0]   div_settle,
    output logic               core_src_alt,
    output logic               perfmon_src,
    output logic [2:0]         core_ratio,
    output logic [2:0]         trace_ratio,
    output logic [2:0]         copy_ratio,
    output logic [2:0]         perfmon_ratio
);
    logic hit_src, hit_mstat, hit_div0, hit_div1, hit_dst0, hit_dst1;
    mux_code_e mcode;
    logic [RATIO_W-1:0] ratio [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] fbusy;
    logic [DATA_W-1:0] div_word [2];
    logic [DATA_W-1:0] dst_word [2];

    assign hit_src   = (bus_addr == ADDR_W'(OFS_SRC));
    assign hit_mstat = (bus_addr == ADDR_W'(OFS_MSTAT));
    assign hit_div0  = (bus_addr == ADDR_W'(OFS_DIV0));
    assign hit_div1  = (bus_addr == ADDR_W'(OFS_DIV1));
    assign hit_dst0  = (bus_addr == ADDR_W'(OFS_DST0));
    assign hit_dst1  = (bus_addr == ADDR_W'(OFS_DST1));

    always_ff @(posedge clk) begin
        if (rst)                  perfmon_src <= 1'b0;
        else if (bus_we && hit_src) perfmon_src <= bus_wdata[PERF_SEL_BIT];
    end

    mux_tracker #(.CNT_W(CNT_W)) u_mux (
        .clk(clk), .rst(rst),
        .wr_en(bus_we && hit_src),
        .sel_new(bus_wdata[CORE_SEL_BIT]),
        .settle(mux_settle),
        .sel(core_src_alt),
        .code(mcode)
    );

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        localparam int LSB = field_lsb(gi);
        localparam int REG = field_reg(gi);
        logic wr_hit;
        assign wr_hit = bus_we && ((REG == 0) ? hit_div0 : hit_div1);
        div_field #(.CNT_W(CNT_W)) u_fld (
            .clk(clk), .rst(rst),
            .wr_en(wr_hit),
            .val_new(bus_wdata[LSB +: RATIO_W]),
            .settle(div_settle),
            .ratio(ratio[gi]),
            .busy(fbusy[gi])
        );
    end

    always_comb begin
        div_word[0] = '0;
        div_word[1] = '0;
        dst_word[0] = '0;
        dst_word[1] = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            div_word[field_reg(i)][field_lsb(i) +: RATIO_W] = ratio[i];
            dst_word[field_reg(i)][field_lsb(i)] = fbusy[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_src) begin
            bus_rdata[CORE_SEL_BIT] = core_src_alt;
            bus_rdata[PERF_SEL_BIT] = perfmon_src;
        end else if (hit_mstat) begin
            bus_rdata[MSTAT_LSB +: 3] = mcode;
        end else if (hit_div0) begin
            bus_rdata = div_word[0];
        end else if (hit_div1) begin
            bus_rdata = div_word[1];
        end else if (hit_dst0) begin
            bus_rdata = dst_word[0];
        end else if (hit_dst1) begin
            bus_rdata = dst_word[1];
        end
    end

    assign core_ratio    = ratio[0];
    assign trace_ratio   = ratio[1];
    assign copy_ratio    = ratio[2];
    assign perfmon_ratio = ratio[3];

    // R9: status and unmapped writes leave the performance-monitor select alone
    p_src_only_r9: assert property (@(posedge clk) disable iff (rst)
        (!(bus_we && hit_src)) |=> $stable(perfmon_src));

    // R10: any changed ratio write keeps the field busy next cycle
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_div0 && bus_wdata[2:0] != core_ratio) |=> fbusy[0]);

endmodule

// File: tb/tb_clkctl_bank.sv
module tb_clkctl_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  mux_settle;
    logic [7:0]  div_settle;
    logic        core_src_alt, perfmon_src;
    logic [2:0]  core_ratio, trace_ratio, copy_ratio, perfmon_ratio;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl_bank dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mux_settle(mux_settle), .div_settle(div_settle),
        .core_src_alt(core_src_alt), .perfmon_src(perfmon_src),
        .core_ratio(core_ratio), .trace_ratio(trace_ratio),
        .copy_ratio(copy_ratio), .perfmon_ratio(perfmon_ratio)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_window(input string tag, input logic [11:0] a,
                                 input logic [31:0] busy_v, input logic [31:0] final_v,
                                 input int n);
        logic [31:0] v;
        for (int k = 0; k < n; k++) begin
            rd(a, v);
            check(tag, v, busy_v);
            @(negedge clk);
        end
        rd(a, v);
        check(tag, v, final_v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h000, v); check("R1 src", v, 32'h0);
        rd(12'h200, v); check("R1 mstat", v, 32'h0001_0000);
        rd(12'h300, v); check("R1 div0", v, 32'h0);
        rd(12'h304, v); check("R1 div1", v, 32'h0);
        rd(12'h400, v); check("R1 dst0", v, 32'h0);
        rd(12'h404, v); check("R1 dst1", v, 32'h0);
        check("R1 outputs", {20'h0, core_src_alt, perfmon_src, core_ratio,
              trace_ratio, copy_ratio, perfmon_ratio}, 32'h0);
    endtask

    task automatic t_src_bits();
        logic [31:0] v;
        wr(12'h000, 32'h0010_00FF);
        rd(12'h000, v); check("R2 readback", v, 32'h0010_0000);
        check("R2 perfmon_src", {31'h0, perfmon_src}, 32'h1);
        rd(12'h200, v); check("R5 no switch", v, 32'h0001_0000);
    endtask

    task automatic t_switch();
        mux_settle = 8'd3;
        wr(12'h000, 32'h0011_0000);
        expect_window("R3 R4 to alt", 12'h200, 32'h0004_0000, 32'h0002_0000, 3);
        check("R2 core_src_alt", {31'h0, core_src_alt}, 32'h1);
        mux_settle = 8'd0;
        wr(12'h000, 32'h0010_0000);
        expect_window("R4 zero settle", 12'h200, 32'h0004_0000, 32'h0001_0000, 1);
    endtask

    task automatic t_same();
        logic [31:0] v;
        wr(12'h000, 32'h0000_0000);
        rd(12'h200, v); check("R5 same sel", v, 32'h0001_0000);
        check("R2 perfmon cleared", {31'h0, perfmon_src}, 32'h0);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        mux_settle = 8'd3;
        wr(12'h000, 32'h0001_0000);
        rd(12'h200, v); check("R10 first", v, 32'h0004_0000);
        @(negedge clk);
        rd(12'h200, v); check("R10 mid", v, 32'h0004_0000);
        wr(12'h000, 32'h0000_0000);
        expect_window("R10 restart", 12'h200, 32'h0004_0000, 32'h0001_0000, 3);
    endtask

    task automatic t_div_both();
        logic [31:0] v;
        div_settle = 8'd5;
        wr(12'h300, 32'hFFFA_FFFB);
        check("R6 core", {29'h0, core_ratio}, 32'h3);
        check("R6 trace", {29'h0, trace_ratio}, 32'h2);
        expect_window("R7 both busy", 12'h400, 32'h0001_0001, 32'h0, 5);
        rd(12'h300, v); check("R6 div0 readback", v, 32'h0002_0003);
    endtask

    task automatic t_div_one();
        logic [31:0] v;
        wr(12'h300, 32'h0002_0005);
        expect_window("R8 trace unchanged", 12'h400, 32'h0000_0001, 32'h0, 5);
        wr(12'h300, 32'h0002_0005);
        rd(12'h400, v); check("R8 identical", v, 32'h0);
    endtask

    task automatic t_div1();
        logic [31:0] v;
        wr(12'h304, 32'h0000_0070);
        check("R6 perfmon", {29'h0, perfmon_ratio}, 32'h7);
        check("R6 copy", {29'h0, copy_ratio}, 32'h0);
        expect_window("R7 div1", 12'h404, 32'h0000_0010, 32'h0, 5);
        rd(12'h304, v); check("R6 div1 readback", v, 32'h0000_0070);
        rd(12'h400, v); check("R7 div0 idle", v, 32'h0);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(12'h400, 32'hFFFF_FFFF);
        wr(12'h404, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h000, v); check("R9 src", v, 32'h0);
        rd(12'h200, v); check("R9 mstat", v, 32'h0001_0000);
        rd(12'h300, v); check("R9 div0", v, 32'h0002_0005);
        rd(12'h304, v); check("R9 div1", v, 32'h0000_0070);
        rd(12'h400, v); check("R9 dst0", v, 32'h0);
        rd(12'h404, v); check("R9 dst1", v, 32'h0);
        rd(12'h100, v); check("R9 unmapped", v, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        mux_settle = 8'd3; div_settle = 8'd5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_src_bits();
        t_switch();
        t_same();
        t_restart();
        t_div_both();
        t_div_one();
        t_div1();
        t_ignore();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule